// File: doc/BRIEF.md
# Instruction Word Fetch Decoder

This block sits between a byte-wide program memory port and an instruction execution stage. Program bytes arrive one at a time, qualified by a valid strobe. The block pairs them into 16-bit instruction words, with the lower-address byte as the low half. It then sorts each word into an operation and collects the operand bits, which the encoding scatters across the word, into fixed output fields.

Two encodings carry a second 16-bit word, which is a data address: the direct register load and the direct register store. For these the block waits for the following word and captures it as the address. Only then does it report the instruction.

Results leave through registers as a one-cycle valid pulse. An unrecognised word produces a valid pulse together with an illegal flag, and its decode is a no-operation.

Top module: `insn_fetch_decoder`

## Requirements
- R1: Each word is built from two accepted bytes (cycles with `byte_valid` high, idle cycles in between allowed). The first byte forms bits 7:0 and the second forms bits 15:8, so bytes 0x82 then 0x0F give 0x0F82, decoded as ADD with Rd=24, Rr=18.
- R2: If the high byte of a one-word instruction, or of the address word, is sampled at edge n, then `dec_valid` is high from edge n+1 to edge n+2. `dec_valid` is never high in two consecutive cycles. Every output field that an operation does not use reads zero.
- R3: Words with bits 15:10 equal to 000011 (ADD), 000111 (ADC), 000110 (SUB), 001000 (AND), 001010 (OR), 001001 (EOR) or 001011 (MOV) report Rd = {bit 8, bits 7:4} and Rr = {bit 9, bits 3:0}.
- R4: When Rd equals Rr, ADD is reported as LSL, ADC as ROL, AND as TST and EOR as CLR.
- R5: Bits 15:12 equal to 0011 (CPI), 0101 (SUBI), 0110 (ORI), 0111 (ANDI) or 1110 (LDI) report `dec_imm` = {bits 11:8, bits 3:0} and Rd = 16 + bits 7:4.
- R6: 1001 000d dddd 0000 (LDS, register on Rd) and 1001 001r rrrr 0000 (STS, register on Rr) produce no valid pulse for their first word. The next word is taken whole as `dec_addr`, and the valid pulse follows it as in R2.
- R7: Bits 15:12 equal to 1100 (RJMP) or 1101 (RCALL) report bits 11:0 on `dec_off`.
- R8: 1111 00kk kkkk ksss is BRBS and 1111 01kk kkkk ksss is BRBC. `dec_sel` gives sss, and `dec_off` gives the 7-bit field k sign-extended to 12 bits.
- R9: For 1001 010d dddd xxxx, the low nibble selects the operation: 0000 COM, 0001 NEG, 0010 SWAP, 0011 INC, 0101 ASR, 0110 LSR, 0111 ROR, 1010 DEC. Rd comes from bits 8:4, and every other nibble is illegal.
- R10: 1011 0AAd dddd AAAA is IN (Rd) and 1011 1AAr rrrr AAAA is OUT (Rr), with `dec_io` = {bits 10:9, bits 3:0}. 1001 10xx AAAA Abbb, with xx set to 00 CBI, 01 SBIC, 10 SBI or 11 SBIS, gives `dec_io` = bits 7:3 and `dec_bit` = bits 2:0.
- R11: The word 0x0000 reports NOP with `dec_illegal` low.
- R12: A word that matches none of the patterns above gives a valid pulse with `dec_illegal` high, `dec_op` = NOP and all fields zero. `dec_illegal` is high only during a valid pulse.
- R13: A synchronous active-high `rst` discards a half-assembled word and a pending first word of LDS/STS, and clears `dec_valid`.

Operation identifiers on `dec_op` are the values of the `ifd_op_e` type in the `ifd_pkg` package.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | A program byte is present this cycle |
| byte_data | input | 8 | Program byte |
| dec_valid | output | 1 | Decoded instruction valid for one cycle |
| dec_illegal | output | 1 | Word matched no pattern |
| dec_op | output | 6 | Operation identifier (`ifd_op_e`) |
| dec_rd | output | 5 | Destination register |
| dec_rr | output | 5 | Source register |
| dec_imm | output | 8 | 8-bit immediate |
| dec_io | output | 6 | I/O address |
| dec_sel | output | 3 | Status bit selector for branches |
| dec_bit | output | 3 | Bit number for bit I/O operations |
| dec_off | output | 12 | Relative offset, two's complement |
| dec_addr | output | 16 | Data address from the second word |

## Verification
The bound assertions check the sequencing rules on every cycle:
- a valid pulse always comes from a completed word and never lasts two cycles;
- the first word of a two-word instruction stays silent;
- a pending load or store always closes on the next word;
- an illegal flag always carries a NOP with empty register fields;
- immediate-class destinations fall in the upper register bank.

The decode of each field needs the bench's scenarios, which compare every valid pulse against an expected item:
- byte order, with and without idle gaps;
- the alias choice when the registers are equal;
- offset sign extension;
- the single-register selector;
- recovery from a reset taken in the middle of a word or between the two words of a load.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 8;
  localparam int IO_W   = 6;
  localparam int SEL_W  = 3;
  localparam int OFF_W  = 12;
  localparam int BR_W   = 7;
  localparam int OP_W   = 6;

  typedef enum logic [OP_W-1:0] {
    OP_NOP, OP_ADD, OP_LSL, OP_ADC, OP_ROL, OP_SUB, OP_AND, OP_TST,
    OP_OR, OP_EOR, OP_CLR, OP_MOV, OP_CPI, OP_SUBI, OP_ORI, OP_ANDI,
    OP_LDI, OP_LDS, OP_STS, OP_RJMP, OP_RCALL, OP_BRBS, OP_BRBC,
    OP_COM, OP_NEG, OP_SWAP, OP_INC, OP_ASR, OP_LSR, OP_ROR, OP_DEC,
    OP_IN, OP_OUT, OP_CBI, OP_SBIC, OP_SBI, OP_SBIS
  } ifd_op_e;

  typedef struct packed {
    ifd_op_e          op;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rr;
    logic [IMM_W-1:0] imm;
    logic [IO_W-1:0]  io;
    logic [SEL_W-1:0] sel;
    logic [SEL_W-1:0] bitn;
    logic [OFF_W-1:0] off;
    logic             illegal;
    logic             two_word;
  } ifd_dec_t;

  function automatic logic [REG_W-1:0] fld_rd5(input logic [WORD_W-1:0] w);
    return {w[8], w[7:4]};
  endfunction

  function automatic logic [REG_W-1:0] fld_rr5(input logic [WORD_W-1:0] w);
    return {w[9], w[3:0]};
  endfunction

  function automatic logic [REG_W-1:0] fld_rd_hi(input logic [WORD_W-1:0] w);
    return {1'b1, w[7:4]};
  endfunction

  function automatic logic [IMM_W-1:0] fld_imm(input logic [WORD_W-1:0] w);
    return {w[11:8], w[3:0]};
  endfunction

  function automatic logic [IO_W-1:0] fld_io6(input logic [WORD_W-1:0] w);
    return {w[10:9], w[3:0]};
  endfunction

  function automatic logic [IO_W-1:0] fld_io5(input logic [WORD_W-1:0] w);
    return {1'b0, w[7:3]};
  endfunction

  function automatic logic [OFF_W-1:0] fld_br_off(input logic [WORD_W-1:0] w);
    return {{(OFF_W-BR_W){w[9]}}, w[9:3]};
  endfunction

  function automatic ifd_dec_t mark_illegal();
    ifd_dec_t d;
    d = '0;
    d.op = OP_NOP;
    d.illegal = 1'b1;
    return d;
  endfunction

  function automatic ifd_dec_t pick_pair(input logic [WORD_W-1:0] w,
                                         input ifd_op_e base, input ifd_op_e alias_op);
    ifd_dec_t d;
    d = '0;
    d.rd = fld_rd5(w);
    d.rr = fld_rr5(w);
    d.op = (d.rd == d.rr) ? alias_op : base;
    return d;
  endfunction

  function automatic ifd_dec_t imm_form(input logic [WORD_W-1:0] w, input ifd_op_e op);
    ifd_dec_t d;
    d = '0;
    d.op  = op;
    d.rd  = fld_rd_hi(w);
    d.imm = fld_imm(w);
    return d;
  endfunction

  function automatic ifd_dec_t single_reg(input logic [WORD_W-1:0] w);
    ifd_dec_t d;
    d = '0;
    d.rd = fld_rd5(w);
    case (w[3:0])
      4'b0000: d.op = OP_COM;
      4'b0001: d.op = OP_NEG;
      4'b0010: d.op = OP_SWAP;
      4'b0011: d.op = OP_INC;
      4'b0101: d.op = OP_ASR;
      4'b0110: d.op = OP_LSR;
      4'b0111: d.op = OP_ROR;
      4'b1010: d.op = OP_DEC;
      default: d = mark_illegal();
    endcase
    return d;
  endfunction

  function automatic ifd_dec_t classify(input logic [WORD_W-1:0] w);
    ifd_dec_t d;
    d = '0;
    d.op = OP_NOP;
    casez (w)
      16'h0000:              d.op = OP_NOP;
      16'b0000_11??_????_????: d = pick_pair(w, OP_ADD, OP_LSL);
      16'b0001_11??_????_????: d = pick_pair(w, OP_ADC, OP_ROL);
      16'b0001_10??_????_????: d = pick_pair(w, OP_SUB, OP_SUB);
      16'b0010_00??_????_????: d = pick_pair(w, OP_AND, OP_TST);
      16'b0010_10??_????_????: d = pick_pair(w, OP_OR,  OP_OR);
      16'b0010_01??_????_????: d = pick_pair(w, OP_EOR, OP_CLR);
      16'b0010_11??_????_????: d = pick_pair(w, OP_MOV, OP_MOV);
      16'b0011_????_????_????: d = imm_form(w, OP_CPI);
      16'b0101_????_????_????: d = imm_form(w, OP_SUBI);
      16'b0110_????_????_????: d = imm_form(w, OP_ORI);
      16'b0111_????_????_????: d = imm_form(w, OP_ANDI);
      16'b1110_????_????_????: d = imm_form(w, OP_LDI);
      16'b1001_000?_????_0000: begin
        d.op = OP_LDS;
        d.rd = fld_rd5(w);
        d.two_word = 1'b1;
      end
      16'b1001_001?_????_0000: begin
        d.op = OP_STS;
        d.rr = fld_rd5(w);
        d.two_word = 1'b1;
      end
      16'b1001_010?_????_????: d = single_reg(w);
      16'b1001_10??_????_????: begin
        d.io   = fld_io5(w);
        d.bitn = w[2:0];
        case (w[9:8])
          2'b00:   d.op = OP_CBI;
          2'b01:   d.op = OP_SBIC;
          2'b10:   d.op = OP_SBI;
          default: d.op = OP_SBIS;
        endcase
      end
      16'b1011_0???_????_????: begin
        d.op = OP_IN;
        d.rd = fld_rd5(w);
        d.io = fld_io6(w);
      end
      16'b1011_1???_????_????: begin
        d.op = OP_OUT;
        d.rr = fld_rd5(w);
        d.io = fld_io6(w);
      end
      16'b1100_????_????_????: begin
        d.op  = OP_RJMP;
        d.off = w[11:0];
      end
      16'b1101_????_????_????: begin
        d.op  = OP_RCALL;
        d.off = w[11:0];
      end
      16'b1111_00??_????_????: begin
        d.op  = OP_BRBS;
        d.sel = w[2:0];
        d.off = fld_br_off(w);
      end
      16'b1111_01??_????_????: begin
        d.op  = OP_BRBC;
        d.sel = w[2:0];
        d.off = fld_br_off(w);
      end
      default: d = mark_illegal();
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ifd_byte_pack.sv
module ifd_byte_pack #(
  parameter int BW = ifd_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_valid,
  input  logic [BW-1:0] byte_data,
  output logic          word_stb,
  output logic [2*BW-1:0] word
);
  logic          half_q;
  logic [BW-1:0] low_q;
  logic [2*BW-1:0] word_q;
  logic          stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      low_q  <= '0;
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (byte_valid) begin
        if (!half_q) begin
          low_q  <= byte_data;
          half_q <= 1'b1;
        end else begin
          word_q <= {byte_data, low_q};
          stb_q  <= 1'b1;
          half_q <= 1'b0;
        end
      end
    end
  end

  assign word_stb = stb_q;
  assign word     = word_q;
endmodule

// File: rtl/ifd_word_decode.sv
module ifd_word_decode
  import ifd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output ifd_dec_t          dec
);
  always_comb dec = classify(word);
endmodule

// File: rtl/ifd_seq.sv
module ifd_seq
  import ifd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word,
  input  ifd_dec_t          dec_in,
  output logic              out_valid,
  output ifd_dec_t          out_dec,
  output logic [WORD_W-1:0] out_addr,
  output logic              pending
);
  logic          pend_q;
  ifd_dec_t      held_q;
  ifd_dec_t      out_q;
  logic          valid_q;
  logic [WORD_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      held_q  <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (word_stb) begin
        if (pend_q) begin
          valid_q <= 1'b1;
          out_q   <= held_q;
          addr_q  <= word;
          pend_q  <= 1'b0;
        end else if (dec_in.two_word) begin
          held_q  <= dec_in;
          pend_q  <= 1'b1;
        end else begin
          valid_q <= 1'b1;
          out_q   <= dec_in;
          addr_q  <= '0;
        end
      end
    end
  end

  assign out_valid = valid_q;
  assign out_dec   = out_q;
  assign out_addr  = addr_q;
  assign pending   = pend_q;
endmodule

// File: rtl/insn_fetch_decoder.sv
module insn_fetch_decoder
  import ifd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic        dec_valid,
  output logic        dec_illegal,
  output logic [5:0]  dec_op,
  output logic [4:0]  dec_rd,
  output logic [4:0]  dec_rr,
  output logic [7:0]  dec_imm,
  output logic [5:0]  dec_io,
  output logic [2:0]  dec_sel,
  output logic [2:0]  dec_bit,
  output logic [11:0] dec_off,
  output logic [15:0] dec_addr
);
  logic              word_stb;
  logic [WORD_W-1:0] word;
  ifd_dec_t          word_dec;
  ifd_dec_t          out_dec;
  logic              out_valid;
  logic              pending;

  ifd_byte_pack #(.BW(BYTE_W)) u_pack (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .word_stb(word_stb), .word(word)
  );

  ifd_word_decode u_dec (.word(word), .dec(word_dec));

  ifd_seq u_seq (
    .clk(clk), .rst(rst), .word_stb(word_stb), .word(word), .dec_in(word_dec),
    .out_valid(out_valid), .out_dec(out_dec), .out_addr(dec_addr), .pending(pending)
  );

  assign dec_valid   = out_valid;
  assign dec_illegal = out_valid & out_dec.illegal;
  assign dec_op      = out_dec.op;
  assign dec_rd      = out_dec.rd;
  assign dec_rr      = out_dec.rr;
  assign dec_imm     = out_dec.imm;
  assign dec_io      = out_dec.io;
  assign dec_sel     = out_dec.sel;
  assign dec_bit     = out_dec.bitn;
  assign dec_off     = out_dec.off;
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker
  import ifd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic       word_stb,
  input logic       pending,
  input logic       dec_valid,
  input logic       dec_illegal,
  input logic [5:0] dec_op,
  input logic [4:0] dec_rd,
  input logic [4:0] dec_rr
);
  logic imm_class;
  assign imm_class = (dec_op == OP_CPI) || (dec_op == OP_SUBI) || (dec_op == OP_ORI) ||
                     (dec_op == OP_ANDI) || (dec_op == OP_LDI);

  AST_WORD_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> $past(byte_valid)); // R1
  AST_VALID_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(word_stb)); // R2
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid); // R2
  AST_UPPER_BANK: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && imm_class) |-> dec_rd[4]); // R5
  AST_FIRST_WORD_SILENT: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> !dec_valid); // R6
  AST_ADDR_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (pending && word_stb) |=> (!pending && dec_valid && (dec_op == OP_LDS || dec_op == OP_STS))); // R6
  AST_ILLEGAL_NOP: assert property (@(posedge clk) disable iff (rst)
    dec_illegal |-> (dec_valid && dec_op == OP_NOP && dec_rd == 5'd0 && dec_rr == 5'd0)); // R12
endmodule

bind insn_fetch_decoder ifd_checker u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .word_stb(word_stb),
  .pending(pending), .dec_valid(dec_valid), .dec_illegal(dec_illegal),
  .dec_op(dec_op), .dec_rd(dec_rd), .dec_rr(dec_rr)
);

// File: tb/insn_fetch_decoder_test.sv
module insn_fetch_decoder_test;
  import ifd_pkg::*;

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  rd;
    logic [4:0]  rr;
    logic [7:0]  imm;
    logic [5:0]  io;
    logic [2:0]  sel;
    logic [2:0]  bitn;
    logic [11:0] off;
    logic [15:0] addr;
    logic        ill;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic dec_valid, dec_illegal;
  logic [5:0] dec_op;
  logic [4:0] dec_rd, dec_rr;
  logic [7:0] dec_imm;
  logic [5:0] dec_io;
  logic [2:0] dec_sel, dec_bit;
  logic [11:0] dec_off;
  logic [15:0] dec_addr;

  int checks = 0;
  int failures = 0;
  exp_t  expq[$];
  string tagq[$];

  insn_fetch_decoder uut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .dec_valid(dec_valid), .dec_illegal(dec_illegal), .dec_op(dec_op),
    .dec_rd(dec_rd), .dec_rr(dec_rr), .dec_imm(dec_imm), .dec_io(dec_io),
    .dec_sel(dec_sel), .dec_bit(dec_bit), .dec_off(dec_off), .dec_addr(dec_addr)
  );

  always #10 clk = ~clk;

  function automatic exp_t blank(input ifd_op_e op);
    exp_t e;
    e = '0;
    e.op = op;
    return e;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    byte_data  = b;
    byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
    byte_data  = 8'h00;
  endtask

  task automatic put_word(input logic [15:0] w, input int gap);
    put_byte(w[7:0]);
    repeat (gap) @(negedge clk);
    put_byte(w[15:8]);
  endtask

  task automatic expect_item(input exp_t e, input string tag);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // monitor: compare every valid pulse against the scoreboard
  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      exp_t act, e;
      string t;
      act = {dec_op, dec_rd, dec_rr, dec_imm, dec_io, dec_sel, dec_bit, dec_off, dec_addr, dec_illegal};
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected valid pulse actual=%h expected=none", act);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        if (act !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    checks++;
    if (dec_valid !== 1'b0 || dec_illegal !== 1'b0) begin
      failures++;
      $display("FAIL R13 reset state actual=%b%b expected=00", dec_valid, dec_illegal);
    end
    rst = 1'b0;
    @(negedge clk);

    // R1 R3: byte order, with and without idle gaps
    e = blank(OP_ADD); e.rd = 5'd24; e.rr = 5'd18;
    expect_item(e, "R1 add r24,r18");
    put_word(16'h0F82, 0);
    e = blank(OP_SUB); e.rd = 5'd3; e.rr = 5'd20;
    expect_item(e, "R3 sub");
    put_word(16'h1A34, 3);
    e = blank(OP_MOV); e.rd = 5'd31; e.rr = 5'd0;
    expect_item(e, "R3 mov");
    put_word(16'h2DF0, 1);
    e = blank(OP_EOR); e.rd = 5'd7; e.rr = 5'd8;
    expect_item(e, "R3 eor distinct");
    put_word(16'h2478, 0);

    // R4 aliases
    e = blank(OP_LSL); e.rd = 5'd5; e.rr = 5'd5;
    expect_item(e, "R4 lsl");
    put_word(16'h0C55, 0);
    e = blank(OP_ROL); e.rd = 5'd17; e.rr = 5'd17;
    expect_item(e, "R4 rol");
    put_word(16'h1F11, 0);
    e = blank(OP_CLR); e.rd = 5'd7; e.rr = 5'd7;
    expect_item(e, "R4 clr");
    put_word(16'h2477, 2);
    e = blank(OP_TST); e.rd = 5'd9; e.rr = 5'd9;
    expect_item(e, "R4 tst");
    put_word(16'h2099, 0);

    // R5 immediates
    e = blank(OP_LDI); e.rd = 5'd16; e.imm = 8'hA5;
    expect_item(e, "R5 ldi");
    put_word(16'hEA05, 0);
    e = blank(OP_CPI); e.rd = 5'd31; e.imm = 8'h3C;
    expect_item(e, "R5 cpi");
    put_word(16'h33FC, 0);

    // R6 two-word direct load and store
    e = blank(OP_LDS); e.rd = 5'd9; e.addr = 16'h1234;
    expect_item(e, "R6 lds");
    put_word(16'h9090, 0);
    repeat (4) @(negedge clk);
    put_word(16'h1234, 1);
    e = blank(OP_STS); e.rr = 5'd26; e.addr = 16'hBEEF;
    expect_item(e, "R6 sts");
    put_word(16'h93A0, 0);
    put_word(16'hBEEF, 0);

    // R7 R8 jumps and branches
    e = blank(OP_RJMP); e.off = 12'hFFE;
    expect_item(e, "R7 rjmp");
    put_word(16'hCFFE, 0);
    e = blank(OP_RCALL); e.off = 12'h005;
    expect_item(e, "R7 rcall");
    put_word(16'hD005, 0);
    e = blank(OP_BRBS); e.sel = 3'd1; e.off = 12'hFFD;
    expect_item(e, "R8 brbs negative");
    put_word(16'hF3E9, 0);
    e = blank(OP_BRBC); e.sel = 3'd7; e.off = 12'h03F;
    expect_item(e, "R8 brbc positive");
    put_word(16'hF5FF, 0);

    // R9 single-register selector
    e = blank(OP_DEC); e.rd = 5'd22;
    expect_item(e, "R9 dec");
    put_word(16'h956A, 0);
    e = blank(OP_SWAP); e.rd = 5'd0;
    expect_item(e, "R9 swap");
    put_word(16'h9402, 0);
    e = blank(OP_NOP); e.ill = 1'b1;
    expect_item(e, "R9 unused selector");
    put_word(16'h9404, 0);

    // R10 I/O forms
    e = blank(OP_IN); e.rd = 5'd12; e.io = 6'h3F;
    expect_item(e, "R10 in");
    put_word(16'hB6CF, 0);
    e = blank(OP_OUT); e.rr = 5'd30; e.io = 6'h21;
    expect_item(e, "R10 out");
    put_word(16'hBDE1, 0);
    e = blank(OP_SBIS); e.io = 6'h1F; e.bitn = 3'd5;
    expect_item(e, "R10 sbis");
    put_word(16'h9BFD, 0);
    e = blank(OP_CBI); e.io = 6'h03; e.bitn = 3'd0;
    expect_item(e, "R10 cbi");
    put_word(16'h9818, 0);

    // R11 R12
    e = blank(OP_NOP);
    expect_item(e, "R11 nop");
    put_word(16'h0000, 0);
    e = blank(OP_NOP); e.ill = 1'b1;
    expect_item(e, "R12 illegal");
    put_word(16'hFFFF, 0);
    repeat (3) @(negedge clk);

    // R13 reset in the middle of a word
    put_byte(8'h11);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    e = blank(OP_ADD); e.rd = 5'd24; e.rr = 5'd18;
    expect_item(e, "R13 after mid-word reset");
    put_word(16'h0F82, 0);
    repeat (3) @(negedge clk);

    // R13 reset between the two words of a load
    put_word(16'h9090, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    e = blank(OP_MOV); e.rd = 5'd31; e.rr = 5'd0;
    expect_item(e, "R13 after pending reset");
    put_word(16'h2DF0, 0);

    repeat (6) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      failures++;
      $display("FAIL R2 missing outputs actual=%0d expected=0", expq.size());
    end
    report();
    $finish;
  end
endmodule